// File: doc/BRIEF.md
# Flash Write-Protection Command Gate

This block sits between the asynchronous bus strobes of a flash memory and its internal command state machine. It decides whether a bus write cycle may be passed on. The chip select, write enable and output enable strobes are all active low. Each one is brought into the clock domain by two flops and then debounced by a filter with a minimum-width setting. A cycle counts only when chip select and write enable are low and output enable is high. The cycle ends on the filtered rising edge of write enable, and at that point the gate may forward it as a one-cycle registered strobe together with the address and data held during the cycle.

A write is discarded in three cases: while the supply-low lockout input is high, when the cycle was already in progress as reset released, or when the write is the final cycle of a program or sector-erase sequence aimed at a protected sector. Each discard is reported on a drop status output that carries a reason code. The gate follows the command unlock sequences so that it can tell which write completes a program or erase. It raises a completion flag only on that write, and only when the target sector is not protected. A command reset output tells the downstream state machine to return to read mode after reset and during lockout.

Top module: `wpg_top`

## Requirements
- R1: A write cycle is forwarded only if the filtered chip select and write enable are low and output enable is high. With output enable held low, or with chip select never low for long enough, no strobe is produced.
- R2: Strobe transitions that last fewer than MIN_W consecutive clock samples are ignored. A write enable low pulse of MIN_W or more samples, with chip select low and output enable high, produces exactly one strobe.
- R3: An accepted write produces a single-cycle wr_stb, and wr_addr/wr_data carry the address and data that were present during the cycle.
- R4: A write that ends while lockout is high is discarded with drop_why = 2'b01. Nothing is queued: no strobe appears after lockout falls.
- R5: cmd_rst is high in every cycle that follows a cycle with lockout high, and lockout returns the sequence tracker to idle.
- R6: A write cycle that is already active as reset releases is not accepted. Its end is reported with drop_why = 2'b10. After write enable has been seen high, the next write is accepted.
- R7: During reset and in the first cycle after it, cmd_rst is high while wr_stb and drop_vld are low.
- R8: wr_final is set together with wr_stb, and only for the last write of one of two sequences. Program is AA@555, 55@2AA, A0@555 followed by any write. Sector erase is AA@555, 55@2AA, 80@555, AA@555, 55@2AA followed by 30 at the sector address. Addresses are compared on addr[10:0] and commands on data[7:0].
- R9: When a final write targets a sector whose bit in sec_prot is set, it is dropped with drop_why = 2'b11 and no strobe. The sector index is addr[ADDR_W-1 -: log2(SECTORS)].
- R10: drop_vld and wr_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| addr | input | ADDR_W | Bus address, held during the write cycle |
| data | input | DATA_W | Bus write data, held during the write cycle |
| vlow | input | 1 | Supply-low lockout flag, synchronous |
| sec_prot | input | SECTORS | Per-sector protect bits |
| wr_stb | output | 1 | Qualified write strobe, one cycle |
| wr_addr | output | ADDR_W | Address of the forwarded write |
| wr_data | output | DATA_W | Data of the forwarded write |
| wr_final | output | 1 | Forwarded write completes a program or sector erase |
| cmd_rst | output | 1 | Command state reset to read mode |
| drop_vld | output | 1 | A write cycle was discarded |
| drop_why | output | 2 | Discard reason: 01 lockout, 10 power-up, 11 protected |

## Verification
Single writes are driven with write enable low for 2, 3, exactly MIN_W and longer sample counts. This tests the filter threshold on both sides of the boundary. Writes with output enable low, and a short chip-select blip under a long write-enable pulse, show that each strobe's polarity is needed on its own. Complete program and erase sequences sent to protected and unprotected sectors tell a protection drop apart from a plain accepted write. A lockout pulse in the middle of a sequence, and a cycle held active across reset, separate the lockout reason from the power-up reason.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3
  } seq_e;

  typedef enum logic [1:0] {
    DR_NONE = 2'b00,
    DR_LOCK = 2'b01,
    DR_PWR  = 2'b10,
    DR_PROT = 2'b11
  } drop_e;

  localparam int LO_A_W = 11;
  localparam logic [LO_A_W-1:0] UNLK_A1 = 11'h555;
  localparam logic [LO_A_W-1:0] UNLK_A2 = 11'h2AA;
  localparam logic [7:0] CMD_K1  = 8'hAA;
  localparam logic [7:0] CMD_K2  = 8'h55;
  localparam logic [7:0] CMD_PGM = 8'hA0;
  localparam logic [7:0] CMD_ERS = 8'h80;
  localparam logic [7:0] CMD_SEC = 8'h30;

  function automatic logic key_hit(input logic [LO_A_W-1:0] a, input logic [7:0] d,
                                   input logic [LO_A_W-1:0] ka, input logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

endpackage

// File: rtl/wpg_glitch_filt.sv
module wpg_glitch_filt #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CNT_W = $clog2(MIN_W + 1);

  logic s1, s2;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      filt <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == filt) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(MIN_W - 1)) begin
        filt <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  filt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> (filt == $past(s2)));

  // R2
  filt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(cnt) == CNT_W'(MIN_W - 1)));

endmodule

// File: rtl/wpg_seq_track.sv
module wpg_seq_track
  import wpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [LO_A_W-1:0] lo_addr,
  input  logic [7:0]        cmd,
  output logic              fin
);
  seq_e st, st_nx;

  assign fin = wr && ((st == SQ_PGM) || ((st == SQ_E3) && (cmd == CMD_SEC)));

  always_comb begin
    st_nx = st;
    if (wr) begin
      unique case (st)
        SQ_IDLE: st_nx = key_hit(lo_addr, cmd, UNLK_A1, CMD_K1) ? SQ_U1 : SQ_IDLE;
        SQ_U1:   st_nx = key_hit(lo_addr, cmd, UNLK_A2, CMD_K2) ? SQ_U2 : SQ_IDLE;
        SQ_U2:   st_nx = key_hit(lo_addr, cmd, UNLK_A1, CMD_PGM) ? SQ_PGM :
                         key_hit(lo_addr, cmd, UNLK_A1, CMD_ERS) ? SQ_E1 : SQ_IDLE;
        SQ_E1:   st_nx = key_hit(lo_addr, cmd, UNLK_A1, CMD_K1) ? SQ_E2 : SQ_IDLE;
        SQ_E2:   st_nx = key_hit(lo_addr, cmd, UNLK_A2, CMD_K2) ? SQ_E3 : SQ_IDLE;
        default: st_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= SQ_IDLE;
    else if (clr) st <= SQ_IDLE;
    else          st <= st_nx;
  end

  // R5
  seq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st == SQ_IDLE));

  // R8
  fin_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (st == SQ_IDLE) || $past(clr));

endmodule

// File: rtl/wpg_top.sv
module wpg_top
  import wpg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SECTORS = 8,
  parameter int MIN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              vlow,
  input  logic [SECTORS-1:0] sec_prot,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_final,
  output logic              cmd_rst,
  output logic              drop_vld,
  output logic [1:0]        drop_why
);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int SETTLE = MIN_W + 4;
  localparam int SET_W  = $clog2(SETTLE + 1);

  function automatic logic [SEC_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SEC_W];
  endfunction

  // strobe filters: bit 0 chip select, 1 write enable, 2 output enable
  logic [2:0] raw_n, filt_n;
  assign raw_n = {oe_n, we_n, cs_n};

  for (genvar g = 0; g < 3; g++) begin : g_filt
    wpg_glitch_filt #(.MIN_W(MIN_W)) i_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_n[g]),
      .filt (filt_n[g])
    );
  end

  logic cyc_act, act_q, end_cyc, settled, armed;
  logic [SET_W-1:0] set_cnt;
  logic [ADDR_W-1:0] hold_a;
  logic [DATA_W-1:0] hold_d;

  assign cyc_act = !filt_n[0] && !filt_n[1] && filt_n[2];
  assign end_cyc = act_q && filt_n[1];
  assign settled = (set_cnt == SET_W'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      set_cnt <= '0;
      armed   <= 1'b0;
      hold_a  <= '0;
      hold_d  <= '0;
    end else begin
      act_q <= cyc_act && settled;
      if (!settled) set_cnt <= set_cnt + 1'b1;
      armed <= armed || (settled && filt_n[1]);
      if (cyc_act) begin
        hold_a <= addr;
        hold_d <= data;
      end
    end
  end

  // event wires
  logic try_wr, seq_fin, prot_hit, pass_wr, drop_now;
  drop_e why_now;

  assign try_wr   = end_cyc && armed && !vlow;
  assign prot_hit = seq_fin && sec_prot[sector_of(hold_a)];
  assign pass_wr  = try_wr && !prot_hit;
  assign drop_now = end_cyc && !pass_wr;

  always_comb begin
    if (vlow)        why_now = DR_LOCK;
    else if (!armed) why_now = DR_PWR;
    else             why_now = DR_PROT;
  end

  wpg_seq_track i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (vlow),
    .wr     (try_wr),
    .lo_addr(hold_a[LO_A_W-1:0]),
    .cmd    (hold_d[7:0]),
    .fin    (seq_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb   <= 1'b0;
      wr_final <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      drop_vld <= 1'b0;
      drop_why <= DR_NONE;
      cmd_rst  <= 1'b1;
    end else begin
      wr_stb   <= pass_wr;
      wr_final <= pass_wr && seq_fin;
      drop_vld <= drop_now;
      drop_why <= drop_now ? why_now : DR_NONE;
      cmd_rst  <= vlow;
      if (pass_wr) begin
        wr_addr <= hold_a;
        wr_data <= hold_d;
      end
    end
  end

  // R4
  lock_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> !wr_stb);

  // R5
  lock_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlow |=> cmd_rst);

  // R6
  armed_before_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(armed));

  // R8
  final_has_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_final |-> wr_stb);

  // R9
  final_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_final |-> !sec_prot[sector_of(wr_addr)]);

  // R10
  stb_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && drop_vld));

  // R1
  stb_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(act_q));

endmodule

// File: tb/test_wpg_top.sv
module test_wpg_top;
  localparam int ADDR_W = 16, DATA_W = 8, SECTORS = 8, MIN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic [SECTORS-1:0] sec_prot = 8'b0000_0100;
  logic wr_stb, wr_final, cmd_rst, drop_vld;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [1:0] drop_why;

  always #2 clk = ~clk;

  wpg_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTORS(SECTORS), .MIN_W(MIN_W)) i_wpg_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .vlow(vlow), .sec_prot(sec_prot),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_final(wr_final),
    .cmd_rst(cmd_rst), .drop_vld(drop_vld), .drop_why(drop_why)
  );

  int n_chk = 0, n_bad = 0;
  int n_stb = 0, n_fin = 0, n_drop = 0;
  logic [ADDR_W-1:0] last_a = '0;
  logic [DATA_W-1:0] last_d = '0;
  logic [1:0] last_why = '0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin n_stb++; last_a = wr_addr; last_d = wr_data; end
      if (wr_final) n_fin++;
      if (drop_vld) begin n_drop++; last_why = drop_why; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input int wlen, input bit oe_lo);
    @(negedge clk);
    addr = a; data = d; cs_n = 1'b0; oe_n = oe_lo ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (wlen) @(negedge clk);
    we_n = 1'b1;
    repeat (12) @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  typedef struct packed {
    logic        lk;
    logic        oe_lo;
    logic [3:0]  len;
    logic [15:0] a;
    logic [7:0]  d;
    logic        stb;
    logic [1:0]  why;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 4'd6, 16'h1234, 8'h5A, 1'b1, 2'b00},
    '{1'b0, 1'b0, 4'd2, 16'h2222, 8'h11, 1'b0, 2'b00},
    '{1'b1, 1'b0, 4'd6, 16'h3333, 8'h22, 1'b0, 2'b01},
    '{1'b0, 1'b0, 4'd3, 16'h4444, 8'h33, 1'b0, 2'b00},
    '{1'b0, 1'b0, 4'd4, 16'h0F0F, 8'hC3, 1'b1, 2'b00},
    '{1'b0, 1'b1, 4'd8, 16'h5555, 8'h44, 1'b0, 2'b00},
    '{1'b0, 1'b0, 4'd9, 16'hFFFF, 8'h00, 1'b1, 2'b00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int s0, f0, d0;
    // R7: reset state
    repeat (4) @(negedge clk);
    chk("R7 cmd_rst in reset", int'(cmd_rst), 1);
    rst_n = 1'b1;
    chk("R7 cmd_rst first cycle", int'(cmd_rst), 1);
    chk("R7 wr_stb after reset", int'(wr_stb), 0);
    chk("R7 drop_vld after reset", int'(drop_vld), 0);
    repeat (3) @(negedge clk);
    chk("R7 cmd_rst released", int'(cmd_rst), 0);
    repeat (20) @(negedge clk);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < NV; i++) begin
      s0 = n_stb; d0 = n_drop;
      @(negedge clk);
      vlow = TBL[i].lk;
      do_write(TBL[i].a, TBL[i].d, int'(TBL[i].len), TBL[i].oe_lo);
      vlow = 1'b0;
      repeat (20) @(negedge clk);
      chk($sformatf("R1 R2 R4 vec%0d strobe count", i), n_stb - s0, int'(TBL[i].stb));
      if (TBL[i].stb) begin
        chk($sformatf("R3 vec%0d addr", i), int'(last_a), int'(TBL[i].a));
        chk($sformatf("R3 vec%0d data", i), int'(last_d), int'(TBL[i].d));
      end
      chk($sformatf("R4 vec%0d drop count", i), n_drop - d0, (TBL[i].why != 2'b00) ? 1 : 0);
      if (TBL[i].why != 2'b00)
        chk($sformatf("R4 vec%0d drop reason", i), int'(last_why), int'(TBL[i].why));
    end

    // R1: short chip-select blip under long write enable
    s0 = n_stb;
    @(negedge clk);
    oe_n = 1'b1; we_n = 1'b0; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    we_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 cs blip no strobe", n_stb - s0, 0);

    // R5: cmd_rst follows lockout
    @(negedge clk); vlow = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 cmd_rst during lockout", int'(cmd_rst), 1);
    vlow = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 cmd_rst after lockout", int'(cmd_rst), 0);

    // R8: program to unprotected sector 1
    f0 = n_fin; s0 = n_stb;
    do_write(16'h0555, 8'hAA, 6, 1'b0);
    do_write(16'h02AA, 8'h55, 6, 1'b0);
    do_write(16'h0555, 8'hA0, 6, 1'b0);
    chk("R8 no final before data", n_fin - f0, 0);
    do_write(16'h2010, 8'h3C, 6, 1'b0);
    chk("R8 program final", n_fin - f0, 1);
    chk("R8 program strobes", n_stb - s0, 4);
    chk("R3 program data", int'(last_d), 16'h3C);

    // R9: program to protected sector 2
    f0 = n_fin; s0 = n_stb; d0 = n_drop;
    do_write(16'h0555, 8'hAA, 6, 1'b0);
    do_write(16'h02AA, 8'h55, 6, 1'b0);
    do_write(16'h0555, 8'hA0, 6, 1'b0);
    do_write(16'h4010, 8'h3C, 6, 1'b0);
    chk("R9 protected no final", n_fin - f0, 0);
    chk("R9 protected strobes", n_stb - s0, 3);
    chk("R9 protected drop", n_drop - d0, 1);
    chk("R9 protected reason", int'(last_why), 3);

    // R8: sector erase of sector 3
    f0 = n_fin;
    do_write(16'h0555, 8'hAA, 6, 1'b0);
    do_write(16'h02AA, 8'h55, 6, 1'b0);
    do_write(16'h0555, 8'h80, 6, 1'b0);
    do_write(16'h0555, 8'hAA, 6, 1'b0);
    do_write(16'h02AA, 8'h55, 6, 1'b0);
    do_write(16'h6000, 8'h30, 6, 1'b0);
    chk("R8 sector erase final", n_fin - f0, 1);
    chk("R8 erase address", int'(last_a), 16'h6000);

    // R8: lone program code is not final
    f0 = n_fin;
    do_write(16'h0555, 8'hA0, 6, 1'b0);
    do_write(16'h2020, 8'h77, 6, 1'b0);
    chk("R8 lone command no final", n_fin - f0, 0);

    // R5: lockout in mid-sequence clears tracker
    f0 = n_fin;
    do_write(16'h0555, 8'hAA, 6, 1'b0);
    do_write(16'h02AA, 8'h55, 6, 1'b0);
    @(negedge clk); vlow = 1'b1;
    repeat (3) @(negedge clk); vlow = 1'b0;
    do_write(16'h0555, 8'hA0, 6, 1'b0);
    do_write(16'h2030, 8'h77, 6, 1'b0);
    chk("R5 lockout clears sequence", n_fin - f0, 0);

    // R6: cycle active through reset
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 16'h1111; data = 8'h99;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    s0 = n_stb; d0 = n_drop;
    repeat (20) @(negedge clk);
    we_n = 1'b1;
    repeat (12) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R6 power-up cycle no strobe", n_stb - s0, 0);
    chk("R6 power-up drop", n_drop - d0, 1);
    chk("R6 power-up reason", int'(last_why), 2);
    s0 = n_stb;
    do_write(16'h1357, 8'h24, 6, 1'b0);
    chk("R6 next write accepted", n_stb - s0, 1);
    chk("R6 next write data", int'(last_d), 16'h24);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule